// File: doc/BRIEF.md
# CAN Error Flag and Error Code Capture Register Block

This block sits between a CAN protocol engine and the CPU. The protocol engine sends single-cycle pulses, one for each kind of fault condition and one for each kind of bus error code. The block catches each pulse in a sticky flag or code bit, so that software can read it later. Each flag has its own enable bit. The enabled, set flags are combined into one error status bit, and one interrupt enable gates that status bit onto the interrupt line.

The CPU uses a byte-wide register bus. A write is applied in the cycle where `bus_we` is high. Reads are combinational from `bus_addr`. Flag and code bits are cleared by writing a 0 to the bit. Writing a 1 leaves the bit as it is, so software can clear exactly the bits it has handled without a read-modify-write race. The code store can collect codes over several errors, or it can keep only the code of the newest error. The transmit and receive error counts come in from the fault-confinement logic and are only mirrored for reading.

Top module: `can_err_regbank`

## Requirements
- R1: After reset, the flag, flag-enable, code-store, status and interrupt-enable registers all read 0x00, and `err_irq` is low.
- R2: A pulse on `flag_evt[i]` sets bit i of the flag register at address 0, and the bit is readable in the following cycle. The bit positions are: 7 bus lock, 6 overload frame, 5 receive overrun, 4 bus-off recovery, 3 bus-off entry, 2 error passive, 1 error warning, 0 bus error.
- R3: A write to address 0 clears every flag bit whose write data is 0. Flag bits whose write data is 1 keep their value.
- R4: If an event pulse and a clearing write hit the same flag bit in the same cycle, the flag is set afterwards.
- R5: Address 1 holds one read/write enable bit per flag, in the same bit positions as the flag register.
- R6: Bit 5 of the status register at address 3 is 1 exactly when some flag is set and enabled. The other bits of address 3 read 0. `err_irq` equals that status bit ANDed with bit 5 of the interrupt-enable register at address 4. Only bit 5 of address 4 is stored; its other bits read 0.
- R7: The code store at address 2 holds the code bits 6 ack-delimiter, 5 dominant-bit, 4 recessive-bit, 3 CRC, 2 ack, 1 form, 0 stuff. A pulse on `code_evt[i]` sets bit i. A write clears the code bits written with 0.
- R8: Bit 7 of address 2 is a read/write mode bit. When it is 1, new codes are ORed into the stored codes.
- R9: When the mode bit is 0, any cycle with a code pulse replaces all stored code bits with that cycle's pulses.
- R10: Address 5 reads the transmit error count and address 6 reads the receive error count. Writes to these addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| flag_evt | input | 8 | Fault condition pulses, one per flag |
| code_evt | input | 7 | Bus error code pulses, one per code bit |
| tx_err_cnt | input | 8 | Transmit error count |
| rx_err_cnt | input | 8 | Receive error count |
| err_irq | output | 1 | Combined error interrupt |

## Verification
The hardest case to reach from the ports is a flag pulse arriving in the same cycle as a software write that clears that same flag. The stimulus lines up a single-cycle `flag_evt` pulse with a write to address 0 in one driven cycle. That write also clears another flag that has no pulse, so one read shows both that the pulse won and that the clear took effect. The switch of the code store between its two modes is also covered: the bench changes the mode bit and then sends a clearing write in the same byte, so both behaviours are checked on the same stored codes.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
   localparam int unsigned REG_ADDR_W  = 3;
   localparam int unsigned IRQ_ERR_BIT = 5;

   typedef enum logic [REG_ADDR_W-1:0] {
      RA_FLAGS    = 3'd0,
      RA_FLAG_EN  = 3'd1,
      RA_CODES    = 3'd2,
      RA_IRQ_STAT = 3'd3,
      RA_IRQ_EN   = 3'd4,
      RA_TX_CNT   = 3'd5,
      RA_RX_CNT   = 3'd6
   } reg_addr_e;
endpackage

// File: rtl/can_err_w0c_reg.sv
module can_err_w0c_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_hit,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] set_i,
   output logic [W-1:0] q
);
   initial assert (W > 0) else $fatal(1, "W must be nonzero");

   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    q[b] <= 1'b0;
         else if (set_i[b])             q[b] <= 1'b1;
         else if (wr_hit && !wdata[b])  q[b] <= 1'b0;
      end

      // R2 / R4: a pulse always leaves the bit set
      a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[b] |=> q[b]);
      // R3: writing 0 clears when no pulse
      a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_hit && !wdata[b] && !set_i[b]) |=> !q[b]);
      // R3: writing 1 keeps the bit
      a_r3_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_hit && wdata[b] && !set_i[b]) |=> $stable(q[b]));
   end
endmodule

// File: rtl/can_err_code_store.sv
module can_err_code_store #(
   parameter int unsigned CODE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [CODE_W:0]   wdata,
   input  logic [CODE_W-1:0] code_evt,
   output logic [CODE_W-1:0] codes,
   output logic              accum
);
   initial assert (CODE_W > 0) else $fatal(1, "CODE_W must be nonzero");

   logic [CODE_W-1:0] keep_mask;
   logic              any_evt;

   assign keep_mask = wr_hit ? wdata[CODE_W-1:0] : {CODE_W{1'b1}};
   assign any_evt   = |code_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      accum <= 1'b0;
      else if (wr_hit) accum <= wdata[CODE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                codes <= '0;
      else if (accum)            codes <= (codes & keep_mask) | code_evt;
      else if (any_evt)          codes <= code_evt;
      else                       codes <= codes & keep_mask;
   end

   // R9: newest code replaces the store in single-code mode
   a_r9_replace: assert property (@(posedge clk) disable iff (!rst_n)
      (!accum && any_evt) |=> (codes == $past(code_evt)));
   // R8: in accumulate mode without a write nothing is lost
   a_r8_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
      (accum && !wr_hit) |=> ((codes & $past(codes)) == $past(codes)));
endmodule

// File: rtl/can_err_regbank.sv
module can_err_regbank
   import can_err_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned FLAG_W = 8,
   parameter int unsigned CODE_W = 7,
   parameter int unsigned CNT_W  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_we,
   input  logic [REG_ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [FLAG_W-1:0]     flag_evt,
   input  logic [CODE_W-1:0]     code_evt,
   input  logic [CNT_W-1:0]      tx_err_cnt,
   input  logic [CNT_W-1:0]      rx_err_cnt,
   output logic                  err_irq
);
   initial begin
      assert (FLAG_W <= DATA_W)      else $fatal(1, "flags wider than bus");
      assert (CODE_W < DATA_W)       else $fatal(1, "no room for mode bit");
      assert (CNT_W <= DATA_W)       else $fatal(1, "counter wider than bus");
      assert (IRQ_ERR_BIT < DATA_W)  else $fatal(1, "status bit off bus");
   end

   logic              wr_flags, wr_en, wr_codes, wr_ier;
   logic [FLAG_W-1:0] flags, flag_en_q;
   logic [CODE_W-1:0] codes;
   logic              accum, ier_q, err_stat;

   assign wr_flags = bus_we && (bus_addr == RA_FLAGS);
   assign wr_en    = bus_we && (bus_addr == RA_FLAG_EN);
   assign wr_codes = bus_we && (bus_addr == RA_CODES);
   assign wr_ier   = bus_we && (bus_addr == RA_IRQ_EN);

   can_err_w0c_reg #(.W(FLAG_W)) i_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_flags),
      .wdata  (bus_wdata[FLAG_W-1:0]),
      .set_i  (flag_evt),
      .q      (flags)
   );

   can_err_code_store #(.CODE_W(CODE_W)) i_codes (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (wr_codes),
      .wdata    (bus_wdata[CODE_W:0]),
      .code_evt (code_evt),
      .codes    (codes),
      .accum    (accum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_en_q <= '0;
      else if (wr_en) flag_en_q <= bus_wdata[FLAG_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ier_q <= 1'b0;
      else if (wr_ier) ier_q <= bus_wdata[IRQ_ERR_BIT];
   end

   assign err_stat = |(flags & flag_en_q);
   assign err_irq  = err_stat & ier_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         RA_FLAGS:    bus_rdata = DATA_W'(flags);
         RA_FLAG_EN:  bus_rdata = DATA_W'(flag_en_q);
         RA_CODES:    bus_rdata = DATA_W'({accum, codes});
         RA_IRQ_STAT: bus_rdata[IRQ_ERR_BIT] = err_stat;
         RA_IRQ_EN:   bus_rdata[IRQ_ERR_BIT] = ier_q;
         RA_TX_CNT:   bus_rdata = DATA_W'(tx_err_cnt);
         RA_RX_CNT:   bus_rdata = DATA_W'(rx_err_cnt);
         default:     bus_rdata = '0;
      endcase
   end

   // R6: no interrupt without a set flag
   a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (flags == '0) |-> !err_irq);
   // R10: writes to the counter addresses leave the flags alone
   a_r10_cnt_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (bus_addr == RA_TX_CNT || bus_addr == RA_RX_CNT) && flag_evt == '0)
      |=> $stable(flags));
endmodule

// File: tb/test_can_err_regbank.sv
module test_can_err_regbank;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] flag_evt = '0;
   logic [6:0] code_evt = '0;
   logic [7:0] tx_err_cnt = 8'h5A;
   logic [7:0] rx_err_cnt = 8'h81;
   logic       err_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   bit mon_req = 1'b0;

   typedef struct packed { logic sel; logic [7:0] exp; } item_t;
   item_t sb_q[$];
   string tag_q[$];

   always #2 clk = ~clk;

   can_err_regbank i_can_err_regbank (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flag_evt(flag_evt),
      .code_evt(code_evt), .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
      .err_irq(err_irq)
   );

   // monitor: compare on the falling edge
   always @(negedge clk) begin
      if (mon_req && sb_q.size() > 0) begin
         item_t it;
         string tg;
         logic [7:0] act;
         it = sb_q.pop_front();
         tg = tag_q.pop_front();
         act = it.sel ? {7'd0, err_irq} : bus_rdata;
         checks++;
         if (act !== it.exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tg, act, it.exp);
         end
      end
   end

   task automatic cyc();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      cyc(); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      cyc(); bus_we = 1'b0;
   endtask

   task automatic expect_rd(input logic [2:0] a, input logic [7:0] e, input string t);
      cyc(); bus_addr = a;
      sb_q.push_back('{1'b0, e}); tag_q.push_back(t); mon_req = 1'b1;
      cyc(); mon_req = 1'b0;
   endtask

   task automatic expect_irq(input logic e, input string t);
      cyc();
      sb_q.push_back('{1'b1, {7'd0, e}}); tag_q.push_back(t); mon_req = 1'b1;
      cyc(); mon_req = 1'b0;
   endtask

   task automatic pulse_flags(input logic [7:0] m);
      cyc(); flag_evt = m;
      cyc(); flag_evt = '0;
   endtask

   task automatic pulse_codes(input logic [6:0] m);
      cyc(); code_evt = m;
      cyc(); code_evt = '0;
   endtask

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      // R1 reset state
      expect_rd(3'd0, 8'h00, "R1 flags");
      expect_rd(3'd1, 8'h00, "R1 enables");
      expect_rd(3'd2, 8'h00, "R1 codes");
      expect_rd(3'd3, 8'h00, "R1 status");
      expect_rd(3'd4, 8'h00, "R1 irq enable");
      expect_irq(1'b0, "R1 irq low");
      // R2 flag capture
      pulse_flags(8'h01); expect_rd(3'd0, 8'h01, "R2 bus error bit0");
      pulse_flags(8'h80); expect_rd(3'd0, 8'h81, "R2 bus lock bit7");
      pulse_flags(8'h24); expect_rd(3'd0, 8'hA5, "R2 overrun+passive");
      // R3 write-zero-to-clear
      wr(3'd0, 8'hFE); expect_rd(3'd0, 8'hA4, "R3 clear bit0");
      wr(3'd0, 8'hFF); expect_rd(3'd0, 8'hA4, "R3 ones keep");
      // R4 event and clear in the same cycle
      cyc(); flag_evt = 8'h01; bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h7E;
      cyc(); flag_evt = '0; bus_we = 1'b0;
      expect_rd(3'd0, 8'h25, "R4 event wins, bit7 cleared");
      // R5 enables
      wr(3'd1, 8'h04); expect_rd(3'd1, 8'h04, "R5 enable readback");
      // R6 status and gating
      expect_rd(3'd3, 8'h20, "R6 status bit5");
      expect_irq(1'b0, "R6 gated by irq enable");
      wr(3'd4, 8'hFF); expect_rd(3'd4, 8'h20, "R6 irq enable only bit5");
      expect_irq(1'b1, "R6 irq raised");
      wr(3'd0, 8'hFB); expect_rd(3'd3, 8'h00, "R6 status drops");
      expect_irq(1'b0, "R6 irq drops");
      wr(3'd1, 8'h01); expect_irq(1'b1, "R6 other enable");
      // R10 counters
      expect_rd(3'd5, 8'h5A, "R10 tx count");
      expect_rd(3'd6, 8'h81, "R10 rx count");
      wr(3'd5, 8'h00); wr(3'd6, 8'h00);
      expect_rd(3'd5, 8'h5A, "R10 tx write ignored");
      expect_rd(3'd6, 8'h81, "R10 rx write ignored");
      expect_rd(3'd0, 8'h21, "R10 flags untouched");
      expect_rd(3'd1, 8'h01, "R10 enables untouched");
      // R7 / R9 single-code mode
      pulse_codes(7'h08); expect_rd(3'd2, 8'h08, "R7 CRC code bit3");
      pulse_codes(7'h41); expect_rd(3'd2, 8'h41, "R9 newest replaces");
      // R8 accumulate mode
      wr(3'd2, 8'hFF); expect_rd(3'd2, 8'hC1, "R8 mode set, codes kept");
      pulse_codes(7'h04); expect_rd(3'd2, 8'hC5, "R8 codes ORed");
      wr(3'd2, 8'hBF); expect_rd(3'd2, 8'h85, "R7 clear bit6");
      wr(3'd2, 8'h7F); expect_rd(3'd2, 8'h05, "R9 back to single mode");
      pulse_codes(7'h10); expect_rd(3'd2, 8'h10, "R9 replace after switch");
      wr(3'd2, 8'h6F); expect_rd(3'd2, 8'h00, "R7 clear in single mode");
      repeat (3) cyc();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule